// File: doc/BRIEF.md
# FPGA Configuration Supervisor Sequencer

This block is the controlling side of an FPGA reload handshake. On a reload request it turns on the FPGA supply enable. It waits for the supply to settle and then drives the active-low program line low for a fixed minimum number of cycles. After the program line is released, it waits for the FPGA to release its open-drain INIT line, which marks the end of configuration-memory clearing.

Next the block pulls INIT low itself for a set number of cycles. This gives a slow serial flash time to wake before the FPGA begins fetching the bitstream. After that it watches DONE for completion and treats INIT going low again as a CRC failure. A watchdog counter turns a stalled handshake into an error.

A separate level request holds the program line low for as long as it is asserted. This keeps the FPGA pins in high impedance so that another agent can reach the flash directly. When the request is dropped, the sequencer resumes at the INIT wait. Four status bits report progress and outcome: busy, done, CRC error and timeout.

Top module: `cfg_supervisor`

## Requirements
- R1: While `rst_n` is low and at the first cycle after reset, `pwr_en`=0, `prog_n`=1, `init_oe`=0 and all four status bits are 0.
- R2: A `start_req` seen while idle, configured or in error raises `pwr_en` at the next edge. `pwr_en` then stays high until reset. `prog_n` stays high for exactly `PWR_CYCLES` cycles of the sequence before it falls. `prog_n` is never low while `pwr_en` is low.
- R3: In a sequence, `prog_n` is low for exactly `PROG_CYCLES` consecutive cycles.
- R4: After `prog_n` rises, the block waits for the synchronized INIT input to read high. It then drives `init_oe`=1 (pulling INIT low) for exactly `WAKE_CYCLES` cycles and releases it. `init_oe` is high only while `stat_busy` is high.
- R5: `init_oe` is never high while `prog_n` is low, or while the FPGA is still holding INIT low for memory clearing.
- R6: `stat_done` follows the DONE input through a 2-flop synchronizer plus one register. DONE read high after the INIT hold ends completes the sequence: `stat_busy` clears and both error bits stay 0.
- R7: After the INIT hold ends and 3 settling cycles have passed, INIT read low without DONE ends the sequence with `stat_crc_err`=1 and `stat_timeout`=0.
- R8: `stat_busy` is 1 from the cycle after a sequence starts until it ends. It is never 1 together with an error bit.
- R9: If DONE has not been seen within `TIMEOUT_CYCLES` cycles after the INIT hold is released, the sequence ends with `stat_timeout`=1 exactly `TIMEOUT_CYCLES` cycles after the release. The same limit applies to waiting for INIT to read high after the program pulse.
- R10: `start_req` while a sequence is in progress is ignored: no second program pulse occurs.
- R11: `hold_req` takes priority over `start_req`. While it is high (entered from idle, configured or error), `prog_n`=0, `pwr_en`=1 and `stat_busy`=0. When it drops, the sequence continues at the INIT wait without a further program pulse.
- R12: Accepting a new start or hold clears `stat_crc_err` and `stat_timeout` at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Reload request, sampled each cycle |
| hold_req | input | 1 | Level request to hold program low for direct flash access |
| init_in | input | 1 | INIT pad level (open-drain, pulled up) |
| done_in | input | 1 | DONE pad level |
| pwr_en | output | 1 | FPGA supply enable |
| prog_n | output | 1 | Active-low program line |
| init_oe | output | 1 | When 1, INIT pad is driven low (value tied to 0) |
| stat_busy | output | 1 | Sequence in progress |
| stat_done | output | 1 | Synchronized DONE level |
| stat_crc_err | output | 1 | Last sequence ended on a CRC failure |
| stat_timeout | output | 1 | Last sequence ended on a watchdog timeout |

## Verification
The bench builds the block with a 4-cycle power settle, an 8-cycle program pulse, a 6-cycle flash-wake hold and a 40-cycle watchdog. These values replace counts of thousands or millions of cycles. With them, every phase width can be counted exactly, and both watchdog exits are reached in a few dozen cycles. A behavioural FPGA model in the bench supplies random clearing and configuration delays. Its outcome mode selects success, CRC failure, a stalled DONE, or a clearing phase that never ends.

// File: rtl/cfgsup_pkg.sv
// Shared state encoding and fixed timing constants for the configuration
// supervisor. Assumes the synchronizer depth below is used by every input.
package cfgsup_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POWER_ON,
        ST_PROG_PULSE,
        ST_WAIT_INIT_HIGH,
        ST_FLASH_WAKE_HOLD,
        ST_WAIT_DONE,
        ST_CONFIGURED,
        ST_ERROR,
        ST_HOLD_PROG
    } cfg_state_e;

    localparam int unsigned SYNC_STAGES   = 2;
    // cycles after the INIT hold ends before a low INIT counts as a CRC fault
    localparam int unsigned SETTLE_CYCLES = 3;

    // True for the states that make up an active reload sequence.
    function automatic logic seq_active(cfg_state_e s);
        return (s == ST_POWER_ON) || (s == ST_PROG_PULSE) ||
               (s == ST_WAIT_INIT_HIGH) || (s == ST_FLASH_WAKE_HOLD) ||
               (s == ST_WAIT_DONE);
    endfunction

endpackage

// File: rtl/cfgsup_sync.sv
// Multi-stage flop synchronizer for asynchronous pad levels.
// Assumes each bit is an independent level; no bus coherency is implied.
module cfgsup_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // shift pad levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/cfgsup_timer.sv
// Saturating cycle counter, cleared whenever the sequencer changes state.
// Assumes the caller compares against limits below the saturation value.
module cfgsup_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [TW-1:0] cnt
);

    // count cycles spent in the current state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != {TW{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/cfgsup_fsm.sv
// Reload sequencer: power settle, program pulse, INIT release wait,
// flash wake hold on INIT, DONE/CRC/timeout watch, and program hold.
// Assumes init_s and done_s are already synchronized and tmr is cleared
// on every state change (tmr == 0 in the first cycle of each state).
module cfgsup_fsm
    import cfgsup_pkg::*;
#(
    parameter int PWR_CYCLES     = 16,
    parameter int PROG_CYCLES    = 64,
    parameter int WAKE_CYCLES    = 256,
    parameter int TIMEOUT_CYCLES = 1024,
    parameter int TW             = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic          hold_req,
    input  logic          init_s,
    input  logic          done_s,
    input  logic [TW-1:0] tmr,
    output cfg_state_e    state,
    output cfg_state_e    nxt,
    output logic          prog_n,
    output logic          init_oe,
    output logic          ev_clear,
    output logic          ev_crc,
    output logic          ev_tmo
);

    localparam logic [TW-1:0] PWR_LAST  = TW'(PWR_CYCLES - 1);
    localparam logic [TW-1:0] PROG_LAST = TW'(PROG_CYCLES - 1);
    localparam logic [TW-1:0] WAKE_LAST = TW'(WAKE_CYCLES - 1);
    localparam logic [TW-1:0] TMO_LAST  = TW'(TIMEOUT_CYCLES - 1);
    localparam logic [TW-1:0] SETTLE    = TW'(SETTLE_CYCLES);

    cfg_state_e state_q;

    // hold the current sequencer state
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    // choose the next state and flag outcome events
    always_comb begin
        nxt      = state_q;
        ev_clear = 1'b0;
        ev_crc   = 1'b0;
        ev_tmo   = 1'b0;
        case (state_q)
            ST_IDLE, ST_CONFIGURED, ST_ERROR: begin
                if (hold_req) begin
                    nxt      = ST_HOLD_PROG;
                    ev_clear = 1'b1;
                end else if (start_req) begin
                    nxt      = ST_POWER_ON;
                    ev_clear = 1'b1;
                end
            end
            ST_POWER_ON: begin
                if (tmr == PWR_LAST) nxt = ST_PROG_PULSE;
            end
            ST_PROG_PULSE: begin
                if (tmr == PROG_LAST) nxt = ST_WAIT_INIT_HIGH;
            end
            ST_WAIT_INIT_HIGH: begin
                if (init_s) begin
                    nxt = ST_FLASH_WAKE_HOLD;
                end else if (tmr == TMO_LAST) begin
                    nxt    = ST_ERROR;
                    ev_tmo = 1'b1;
                end
            end
            ST_FLASH_WAKE_HOLD: begin
                if (tmr == WAKE_LAST) nxt = ST_WAIT_DONE;
            end
            ST_WAIT_DONE: begin
                if (done_s) begin
                    nxt = ST_CONFIGURED;
                end else if ((tmr >= SETTLE) && !init_s) begin
                    nxt    = ST_ERROR;
                    ev_crc = 1'b1;
                end else if (tmr == TMO_LAST) begin
                    nxt    = ST_ERROR;
                    ev_tmo = 1'b1;
                end
            end
            ST_HOLD_PROG: begin
                if (!hold_req) nxt = ST_WAIT_INIT_HIGH;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // decode pad drives from the current state
    always_comb begin
        prog_n  = !((state_q == ST_PROG_PULSE) || (state_q == ST_HOLD_PROG));
        init_oe = (state_q == ST_FLASH_WAKE_HOLD);
    end

    assign state = state_q;

endmodule

// File: rtl/cfgsup_status.sv
// Status and power-enable registers, updated from the next state so that
// they line up with the sequencer state each cycle.
// Assumes ev_clear never coincides with ev_crc or ev_tmo.
module cfgsup_status
    import cfgsup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cfg_state_e nxt,
    input  logic       done_s,
    input  logic       ev_clear,
    input  logic       ev_crc,
    input  logic       ev_tmo,
    output logic       pwr_en,
    output logic       busy,
    output logic       done,
    output logic       crc_err,
    output logic       timeout
);

    // supply enable latches on once any activity leaves idle
    always_ff @(posedge clk) begin
        if (!rst_n) pwr_en <= 1'b0;
        else        pwr_en <= pwr_en | (nxt != ST_IDLE);
    end

    // busy and done level bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            busy <= seq_active(nxt);
            done <= done_s;
        end
    end

    // sticky outcome flags, cleared when a new request is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_err <= 1'b0;
            timeout <= 1'b0;
        end else if (ev_clear) begin
            crc_err <= 1'b0;
            timeout <= 1'b0;
        end else begin
            if (ev_crc) crc_err <= 1'b1;
            if (ev_tmo) timeout <= 1'b1;
        end
    end

endmodule

// File: rtl/cfg_supervisor.sv
// Top of the FPGA configuration supervisor. Synchronizes INIT and DONE,
// times each phase with one shared counter and reports four status bits.
// Assumes INIT and DONE pads are pulled up externally and init_oe drives
// the INIT pad to 0 only (open drain). TIMEOUT_CYCLES must exceed 3.
module cfg_supervisor #(
    parameter int PWR_CYCLES     = 1000,
    parameter int PROG_CYCLES    = 64,
    parameter int WAKE_CYCLES    = 250000,
    parameter int TIMEOUT_CYCLES = 10000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic hold_req,
    input  logic init_in,
    input  logic done_in,
    output logic pwr_en,
    output logic prog_n,
    output logic init_oe,
    output logic stat_busy,
    output logic stat_done,
    output logic stat_crc_err,
    output logic stat_timeout
);
    import cfgsup_pkg::*;

    localparam int MAX_AB = (PWR_CYCLES > PROG_CYCLES) ? PWR_CYCLES : PROG_CYCLES;
    localparam int MAX_CD = (WAKE_CYCLES > TIMEOUT_CYCLES) ? WAKE_CYCLES : TIMEOUT_CYCLES;
    localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int TW     = $clog2(MAX_C + 1);

    logic [1:0]    pad_s;
    logic          init_s;
    logic          done_s;
    logic [TW-1:0] tmr;
    cfg_state_e    state;
    cfg_state_e    nxt;
    logic          ev_clear;
    logic          ev_crc;
    logic          ev_tmo;

    cfgsup_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({done_in, init_in}),
        .q     (pad_s)
    );
    assign init_s = pad_s[0];
    assign done_s = pad_s[1];

    cfgsup_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (nxt != state),
        .cnt   (tmr)
    );

    cfgsup_fsm #(
        .PWR_CYCLES     (PWR_CYCLES),
        .PROG_CYCLES    (PROG_CYCLES),
        .WAKE_CYCLES    (WAKE_CYCLES),
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
        .TW             (TW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .hold_req  (hold_req),
        .init_s    (init_s),
        .done_s    (done_s),
        .tmr       (tmr),
        .state     (state),
        .nxt       (nxt),
        .prog_n    (prog_n),
        .init_oe   (init_oe),
        .ev_clear  (ev_clear),
        .ev_crc    (ev_crc),
        .ev_tmo    (ev_tmo)
    );

    cfgsup_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt      (nxt),
        .done_s   (done_s),
        .ev_clear (ev_clear),
        .ev_crc   (ev_crc),
        .ev_tmo   (ev_tmo),
        .pwr_en   (pwr_en),
        .busy     (stat_busy),
        .done     (stat_done),
        .crc_err  (stat_crc_err),
        .timeout  (stat_timeout)
    );

endmodule

// File: rtl/cfg_supervisor_chk.sv
// Property checker for the configuration supervisor, bound to the top.
// Assumes only the top-level ports are visible.
module cfg_supervisor_chk #(
    parameter int PROG_CYCLES = 64
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_en,
    input logic prog_n,
    input logic init_oe,
    input logic stat_busy,
    input logic stat_crc_err,
    input logic stat_timeout
);

    localparam int CW = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] CMAX = CW'(PROG_CYCLES);

    logic [CW-1:0] low_cnt;

    // measure how long program has been low, saturating at the minimum
    always_ff @(posedge clk) begin
        if (!rst_n)            low_cnt <= '0;
        else if (prog_n)       low_cnt <= '0;
        else if (low_cnt != CMAX) low_cnt <= low_cnt + 1'b1;
    end

    AST_PROG_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> pwr_en);                                   // R2
    AST_PWR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_en) |-> pwr_en);                             // R2
    AST_PROG_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_n) |-> (low_cnt == CMAX));                  // R3
    AST_OE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        init_oe |-> stat_busy);                                // R4
    AST_OE_NOT_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        init_oe |-> prog_n);                                   // R5
    AST_OE_RISE_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_oe) |-> $past(prog_n));                     // R5
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_crc_err && stat_timeout));                      // R7
    AST_BUSY_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        stat_busy |-> (!stat_crc_err && !stat_timeout));       // R8

endmodule

bind cfg_supervisor cfg_supervisor_chk #(.PROG_CYCLES(PROG_CYCLES)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_en       (pwr_en),
    .prog_n       (prog_n),
    .init_oe      (init_oe),
    .stat_busy    (stat_busy),
    .stat_crc_err (stat_crc_err),
    .stat_timeout (stat_timeout)
);

// File: tb/cfg_supervisor_tb_top.sv
// Bench: behavioural FPGA model, directed corners and seeded random runs.
module cfg_supervisor_tb_top;

    localparam int PWR  = 4;
    localparam int PRG  = 8;
    localparam int WAKE = 6;
    localparam int TMO  = 40;

    localparam int P_OFF = 0, P_CLEAR = 1, P_WAITPAD = 2, P_CFG = 3, P_FIN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0;
    logic hold_req = 1'b0;
    logic done_in;
    logic init_pad;
    logic pwr_en, prog_n, init_oe;
    logic stat_busy, stat_done, stat_crc_err, stat_timeout;

    int n_tests = 0;
    int n_fail  = 0;

    // model knobs (written at posedge, read at negedge)
    int m_mode = 0;
    int m_clr  = 5;
    int m_cfg  = 5;
    // model state
    int   phase = P_OFF;
    int   mcnt  = 0;
    logic fpga_low = 1'b0;
    logic fpga_done = 1'b0;

    // monitor state
    logic mon_clr = 1'b0;
    int   prog_falls = 0, prog_run = 0, prog_w = 0;
    int   oe_run = 0, oe_w = 0, lead = 0, wait_cnt = 0;
    int   pwr_viol = 0, oe_viol = 0;
    logic prog_prev = 1'b1, oe_prev = 1'b0;

    always #2 clk = ~clk;

    assign init_pad = !(init_oe || fpga_low);
    assign done_in  = fpga_done;

    cfg_supervisor #(
        .PWR_CYCLES(PWR), .PROG_CYCLES(PRG),
        .WAKE_CYCLES(WAKE), .TIMEOUT_CYCLES(TMO)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .hold_req(hold_req),
        .init_in(init_pad), .done_in(done_in), .pwr_en(pwr_en), .prog_n(prog_n),
        .init_oe(init_oe), .stat_busy(stat_busy), .stat_done(stat_done),
        .stat_crc_err(stat_crc_err), .stat_timeout(stat_timeout)
    );

    // FPGA model: clears while program is low, releases INIT, then configures
    always @(negedge clk) begin
        if (!rst_n) begin
            phase <= P_OFF; mcnt <= 0; fpga_low <= 1'b0; fpga_done <= 1'b0;
        end else if (!prog_n) begin
            phase <= P_CLEAR; mcnt <= 0; fpga_low <= 1'b1; fpga_done <= 1'b0;
        end else begin
            case (phase)
                P_CLEAR: if (m_mode != 3) begin
                    if (mcnt >= m_clr) begin fpga_low <= 1'b0; phase <= P_WAITPAD; end
                    else mcnt <= mcnt + 1;
                end
                P_WAITPAD: if (init_pad) begin phase <= P_CFG; mcnt <= 0; end
                P_CFG: begin
                    if (mcnt >= m_cfg) begin
                        if (m_mode == 0) fpga_done <= 1'b1;
                        if (m_mode == 1) fpga_low <= 1'b1;
                        phase <= P_FIN;
                    end else mcnt <= mcnt + 1;
                end
                default: ;
            endcase
        end
    end

    // output monitor: pulse widths, lead time, wait length, rule violations
    always @(negedge clk) begin
        if (mon_clr) begin
            prog_falls = 0; prog_run = 0; prog_w = 0; oe_run = 0; oe_w = 0;
            lead = 0; wait_cnt = 0; pwr_viol = 0; oe_viol = 0;
        end else if (rst_n) begin
            if (!prog_n) prog_run++;
            if (!prog_n && prog_prev) prog_falls++;
            if (prog_n && !prog_prev) prog_w = prog_run;
            if (prog_n) prog_run = 0;
            if (init_oe) oe_run++;
            if (!init_oe && oe_prev) oe_w = oe_run;
            if (!init_oe) oe_run = 0;
            if (stat_busy && prog_n && prog_falls == 0) lead++;
            if (init_oe) wait_cnt = 0;
            else if (stat_busy) wait_cnt++;
            if (!prog_n && !pwr_en) pwr_viol++;
            if (init_oe && (!prog_n || phase == P_CLEAR)) oe_viol++;
        end
        prog_prev = prog_n;
        oe_prev   = init_oe;
    end

    task automatic chk(input string req, input string what, input int act, input int exp_v);
        n_tests++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    // expected outcome: 0 done, 1 CRC error, 2 timeout
    function automatic int exp_outcome(input int mode);
        if (mode == 0) return 0;
        if (mode == 1) return 1;
        return 2;
    endfunction

    task automatic clear_mon();
        @(posedge clk); mon_clr = 1'b1;
        @(posedge clk); mon_clr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 2000 && stat_busy; n++) @(negedge clk);
    endtask

    task automatic check_outcome(input int mode);
        int e;
        e = exp_outcome(mode);
        chk("R6", "done bit", int'(stat_done), int'(e == 0));
        chk("R7", "crc bit", int'(stat_crc_err), int'(e == 1));
        chk("R9", "timeout bit", int'(stat_timeout), int'(e == 2));
        chk("R8", "busy after end", int'(stat_busy), 0);
        chk("R5", "init drive violations", oe_viol, 0);
        chk("R2", "program low without power", pwr_viol, 0);
    endtask

    task automatic run_seq(input int mode, input int clr, input int cfg, input bit extra);
        @(posedge clk); m_mode = mode; m_clr = clr; m_cfg = cfg;
        clear_mon();
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
        chk("R12", "crc cleared on start", int'(stat_crc_err), 0);
        chk("R12", "timeout cleared on start", int'(stat_timeout), 0);
        chk("R8", "busy after start", int'(stat_busy), 1);
        if (extra) begin
            repeat (15) @(negedge clk);
            start_req = 1'b1; @(negedge clk); start_req = 1'b0;
        end
        wait_idle();
        check_outcome(mode);
        chk("R2", "power lead cycles", lead, PWR);
        chk("R3", "program pulse width", prog_w, PRG);
        chk("R10", "program pulse count", prog_falls, 1);
        chk("R4", "INIT hold width", oe_w, (mode == 3) ? 0 : WAKE);
        if (mode == 2) chk("R9", "cycles to timeout", wait_cnt, TMO);
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual hung expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state, during and just after reset
        chk("R1", "pwr_en in reset", int'(pwr_en), 0);
        chk("R1", "prog_n in reset", int'(prog_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "init_oe after reset", int'(init_oe), 0);
        chk("R1", "status after reset",
            int'({stat_busy, stat_done, stat_crc_err, stat_timeout}), 0);
        chk("R2", "power off before start", int'(pwr_en), 0);

        run_seq(0, 10, 5, 1'b0);                 // success from idle
        chk("R2", "power on after sequence", int'(pwr_en), 1);
        run_seq(1, 3, 4, 1'b0);                  // CRC failure
        run_seq(0, 7, 2, 1'b0);                  // R12 flags cleared then success
        run_seq(2, 5, 5, 1'b0);                  // DONE never rises
        run_seq(3, 5, 5, 1'b0);                  // clearing never ends
        run_seq(0, 20, 8, 1'b1);                 // R10 start while busy

        // R11: hold program low for direct flash access
        @(posedge clk); m_mode = 0; m_clr = 6; m_cfg = 3;
        clear_mon();
        @(negedge clk); hold_req = 1'b1; start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
        repeat (12) @(negedge clk);
        chk("R11", "prog_n while held", int'(prog_n), 0);
        chk("R11", "pwr_en while held", int'(pwr_en), 1);
        chk("R11", "busy while held", int'(stat_busy), 0);
        chk("R6", "done drops while held", int'(stat_done), 0);
        hold_req = 1'b0;
        @(negedge clk);
        chk("R11", "busy after release", int'(stat_busy), 1);
        wait_idle();
        check_outcome(0);
        chk("R11", "no extra program pulse", prog_falls, 1);
        chk("R4", "INIT hold width after hold", oe_w, WAKE);

        // seeded random runs
        for (int i = 0; i < 12; i++) begin
            run_seq($urandom % 4, 1 + ($urandom % 30), 1 + ($urandom % 20), 1'b0);
        end
        chk("R2", "power stays on", int'(pwr_en), 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule